// File: doc/BRIEF.md
# Serial ADC Device-Side Interface

This block acts as the converter side of a four-wire serial link. A master pulls an active-low chip select, toggles a serial clock that idles high, and sends a bit stream on the data-in line. During each 16-bit frame the block sends a result word on the data-out line and collects a 3-bit channel address from the data-in line. All three link inputs are oversampled in the block's own, much faster system clock.

Conversion results are not produced by an analog model. They come from eight 12-bit parallel registers, one per channel, that the surrounding logic keeps up to date. The channel addressed in one frame picks the register whose value is returned in the next frame. This matches the pipelined addressing of a real multi-channel converter.

At the end of each complete frame, the block gives a one-cycle done strobe and shows the captured channel number on a parallel output.

Top module: `adc_link_slave`

## Requirements
- R1: A frame is complete on the 16th rising serial clock edge after chip select falls. One system clock later, `frameDone` is high for exactly one cycle, and `chanOut` shows the channel captured in that frame. Rising edges after the 16th and before chip select rises are ignored.
- R2: The data-out word is 16 bits, sent MSB first. Bits 15..12 are zero and bits 11..0 are the selected 12-bit result. Each bit is updated after a falling serial clock edge, so it is stable at the next rising edge.
- R3: Data-in is sampled on rising serial clock edges. The 3rd, 4th and 5th sampled bits of a frame form the channel number, MSB first. The first two and the last eleven sampled bits have no effect.
- R4: The channel captured in frame N selects which input register is returned in frame N+1. After reset, channel 0 is selected and `chanOut` reads 0.
- R5: The result word is taken from the selected register when chip select falls. Later changes to that register during the frame do not change the bits that are sent.
- R6: While chip select is high, `sdoOut` is 0.
- R7: If chip select rises before the 16th rising edge, the frame is aborted. There is no `frameDone` pulse, the selected channel is unchanged, and the next frame starts again at bit 0.
- R8: The link works for any serial clock whose half period is at least 8 system clock cycles. This covers rates from 50 kHz up to the top rate the system clock permits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock from the master, idles high |
| csNIn | input | 1 | Active-low chip select from the master |
| sdiIn | input | 1 | Serial data from the master |
| chanData | input | 96 | Eight 12-bit results; channel k is in bits 12k+11..12k |
| sdoOut | output | 1 | Serial data to the master |
| frameDone | output | 1 | One-cycle strobe at the end of a complete frame |
| chanOut | output | 3 | Channel captured in the most recent complete frame |

## Verification
The assertions assume that the three link inputs are clean levels. They also assume that the serial clock stays high whenever chip select changes, and that each serial clock level lasts long enough for the synchronizers to see it. The bench keeps within these assumptions:
- It moves chip select only while the serial clock is high, with at least one half period of margin.
- It changes data-in only on the falling serial edge.
- It uses half periods of 8, 13 and 2000 system cycles.
- It launches every link edge one nanosecond after a system clock edge, so that no edge lands on a sampling instant.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;

  // Strobes from the control unit to the datapath, all one system cycle wide
  typedef struct packed {
    logic loadWord;   // chip select fell: latch the selected result
    logic shiftOut;   // falling serial edge inside a frame: advance data-out
    logic takeChan;   // rising serial edge within the channel field
    logic frameEnd;   // 16th rising serial edge
  } ctlStrobes_t;

endpackage

// File: rtl/adc_link_sync.sv
module adc_link_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/adc_link_ctl.sv
module adc_link_ctl
  import adc_link_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int CHAN_N = 8,
  parameter int CHAN_POS = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkRaw,
  input  logic        csNRaw,
  input  logic        sdiRaw,
  output ctlStrobes_t st,
  output logic        sdiSync,
  output logic        csIdle
);

  localparam int CHAN_W = $clog2(CHAN_N);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] CHAN_LO = CNT_W'(CHAN_POS);
  localparam logic [CNT_W-1:0] CHAN_HI = CNT_W'(CHAN_POS + CHAN_W - 1);

  logic [2:0] syncQ;
  logic sclkS, csS;
  logic sclkD, csD;
  logic sclkRise, sclkFall, csFall;
  logic [CNT_W-1:0] bitCnt;

  // serial clock and chip select reset high (idle), data-in resets low
  adc_link_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) sync_i (
    .clk (clk),
    .rstN(rstN),
    .d   ({sclkRaw, csNRaw, sdiRaw}),
    .q   (syncQ)
  );

  assign sclkS   = syncQ[2];
  assign csS     = syncQ[1];
  assign sdiSync = syncQ[0];
  assign csIdle  = csS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkD <= 1'b1;
      csD   <= 1'b1;
    end else begin
      sclkD <= sclkS;
      csD   <= csS;
    end
  end

  assign sclkRise = sclkS & ~sclkD;
  assign sclkFall = ~sclkS & sclkD;
  assign csFall   = ~csS & csD;

  // counts rising edges in the frame, saturates at FRAME_LEN, cleared by chip select high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (csS) begin
      bitCnt <= '0;
    end else if (sclkRise && bitCnt != CNT_FULL) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    st.loadWord = csFall;
    st.shiftOut = sclkFall && !csS && bitCnt != '0 && bitCnt != CNT_FULL;
    st.takeChan = sclkRise && !csS && bitCnt >= CHAN_LO && bitCnt <= CHAN_HI;
    st.frameEnd = sclkRise && !csS && bitCnt == CNT_LAST;
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_FULL);

  p_end_once_r1: assert property (@(posedge clk) disable iff (!rstN)
    st.frameEnd |=> !st.frameEnd);

  p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> bitCnt == '0);

  p_no_shift_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    csS |-> !st.shiftOut && !st.takeChan && !st.frameEnd);

endmodule

// File: rtl/adc_link_dp.sv
module adc_link_dp
  import adc_link_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CHAN_N = 8,
  parameter int FRAME_LEN = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobes_t              st,
  input  logic                     sdiSync,
  input  logic                     csIdle,
  input  logic [CHAN_N*DATA_W-1:0] chanData,
  output logic                     sdo,
  output logic                     frameDone,
  output logic [$clog2(CHAN_N)-1:0] chanSel
);

  localparam int CHAN_W = $clog2(CHAN_N);
  localparam int LEAD_Z = FRAME_LEN - DATA_W;

  logic [DATA_W-1:0] chanArr [CHAN_N];
  logic [FRAME_LEN-1:0] outWord;
  logic [CHAN_W-1:0] chanShift;
  logic [CHAN_W-1:0] selChan;

  for (genvar g = 0; g < CHAN_N; g++) begin : g_unpack
    assign chanArr[g] = chanData[g*DATA_W +: DATA_W];
  end

  // result word: latched at frame start, shifted after each falling edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWord <= '0;
    end else if (st.loadWord) begin
      outWord <= {{LEAD_Z{1'b0}}, chanArr[selChan]};
    end else if (st.shiftOut) begin
      outWord <= {outWord[FRAME_LEN-2:0], 1'b0};
    end
  end

  // channel field collection and frame-end commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanShift <= '0;
      selChan   <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= st.frameEnd;
      if (st.takeChan) chanShift <= {chanShift[CHAN_W-2:0], sdiSync};
      if (st.frameEnd) selChan <= chanShift;
    end
  end

  assign sdo     = !csIdle && outWord[FRAME_LEN-1];
  assign chanSel = selChan;

  p_lead_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    st.loadWord |=> outWord[FRAME_LEN-1:DATA_W] == '0);

  p_word_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !st.loadWord && !st.shiftOut |=> $stable(outWord));

  p_chan_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !st.frameEnd |=> $stable(selChan));

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

endmodule

// File: rtl/adc_link_slave.sv
module adc_link_slave #(
  parameter int DATA_W = 12,
  parameter int CHAN_N = 8,
  parameter int FRAME_LEN = 16,
  parameter int CHAN_POS = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sclkIn,
  input  logic                      csNIn,
  input  logic                      sdiIn,
  input  logic [CHAN_N*DATA_W-1:0]  chanData,
  output logic                      sdoOut,
  output logic                      frameDone,
  output logic [$clog2(CHAN_N)-1:0] chanOut
);

  adc_link_pkg::ctlStrobes_t st;
  logic sdiSync;
  logic csIdle;

  adc_link_ctl #(
    .FRAME_LEN(FRAME_LEN), .CHAN_N(CHAN_N),
    .CHAN_POS(CHAN_POS), .SYNC_STAGES(SYNC_STAGES)
  ) ctl_i (
    .clk    (clk),
    .rstN   (rstN),
    .sclkRaw(sclkIn),
    .csNRaw (csNIn),
    .sdiRaw (sdiIn),
    .st     (st),
    .sdiSync(sdiSync),
    .csIdle (csIdle)
  );

  adc_link_dp #(
    .DATA_W(DATA_W), .CHAN_N(CHAN_N), .FRAME_LEN(FRAME_LEN)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .sdiSync  (sdiSync),
    .csIdle   (csIdle),
    .chanData (chanData),
    .sdo      (sdoOut),
    .frameDone(frameDone),
    .chanSel  (chanOut)
  );

  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    csIdle |-> !sdoOut);

endmodule

// File: tb/adc_link_slave_tb_top.sv
`timescale 1ns/1ps
module adc_link_slave_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b1;
  logic csNIn = 1'b1;
  logic sdiIn = 1'b0;
  logic [95:0] chanData;
  logic sdoOut;
  logic frameDone;
  logic [2:0] chanOut;

  logic [11:0] regs [8];
  logic [15:0] expWordQ [$];
  logic [2:0] expChanQ [$];
  logic [15:0] rxWord;
  logic [2:0] expSel;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < 8; k++) chanData[k*12 +: 12] = regs[k];
  end

  adc_link_slave dut_i (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csNIn(csNIn), .sdiIn(sdiIn),
    .chanData(chanData), .sdoOut(sdoOut), .frameDone(frameDone), .chanOut(chanOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver: one frame; abortAt < 16 raises chip select early
  task automatic sendFrame(input logic [2:0] ch, input logic junk, input int half,
                           input int abortAt, input bit poke);
    logic [15:0] tx;
    tx = {junk, junk, ch, {11{junk}}};
    if (abortAt >= 16) begin
      expWordQ.push_back({4'b0000, regs[expSel]});
      expChanQ.push_back(ch);
    end
    csNIn = 1'b0;
    waitCyc(half);
    for (int i = 0; i < 16; i++) begin
      if (i == abortAt) break;
      sclkIn = 1'b0;
      sdiIn = tx[15-i];
      waitCyc(half);
      sclkIn = 1'b1;
      if (poke && i == 6) regs[expSel] = ~regs[expSel];
      waitCyc(half);
    end
    waitCyc(half);
    csNIn = 1'b1;
    if (abortAt >= 16) expSel = ch;
    waitCyc(6);
    check(sdoOut == 1'b0, "R6 sdo idle", sdoOut, 0);
  endtask

  // monitor: master-side sampling of data-out on rising serial edges
  always @(negedge csNIn) rxWord = '0;
  always @(posedge sclkIn) if (!csNIn) rxWord = {rxWord[14:0], sdoOut};

  always @(negedge clk) begin
    if (rstN && frameDone) begin
      if (expWordQ.size() == 0) begin
        check(1'b0, "R7 unexpected frameDone", 1, 0);
      end else begin
        logic [15:0] ew;
        logic [2:0] ec;
        ew = expWordQ.pop_front();
        ec = expChanQ.pop_front();
        check(rxWord == ew, "R2 R4 R5 word", rxWord, ew);
        check(chanOut == ec, "R3 R1 chanOut", chanOut, ec);
        @(negedge clk);
        check(frameDone == 1'b0, "R1 pulse width", frameDone, 0);
      end
    end
  end

  initial begin
    expSel = 3'd0;
    for (int k = 0; k < 8; k++) regs[k] = 12'(12'hA53 + k * 12'h1F7);
    waitCyc(5);
    check(sdoOut == 1'b0, "R6 reset sdo", sdoOut, 0);
    check(frameDone == 1'b0, "R1 reset done", frameDone, 0);
    check(chanOut == 3'd0, "R4 reset chan", chanOut, 0);
    rstN = 1'b1;
    waitCyc(5);
    sendFrame(3'd5, 1'b0, 13, 16, 1'b0);          // R4 reset channel 0 returned
    sendFrame(3'd2, 1'b1, 13, 16, 1'b0);          // R3 junk bits high
    sendFrame(3'd7, 1'b0, 13, 7, 1'b0);           // R7 abort
    check(chanOut == 3'd2, "R7 channel kept", chanOut, 2);
    sendFrame(3'd3, 1'b1, 13, 16, 1'b1);          // R5 register changed mid-frame
    sendFrame(3'd0, 1'b0, 2000, 16, 1'b0);        // R8 slow rate
    sendFrame(3'd6, 1'b1, 8, 16, 1'b0);           // R8 fastest allowed
    sendFrame(3'd1, 1'b0, 8, 16, 1'b0);
    waitCyc(20);
    check(expWordQ.size() == 0, "R1 all frames done", expWordQ.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule